// File: doc/BRIEF.md
# Gamma-Corrected Bit-Plane Column Driver

This block drives the twelve column lines of one row of an LED matrix with binary code modulation. Software, or a neighbouring block, keeps an 8-bit brightness for every cell of an 8-row by 12-column matrix by writing through a simple cell-write port. The external row scanner selects a row and pulses `frame_start` with that row's index. The driver then reads the twelve brightness values of the row. It turns each value into a 12-bit intensity code along a square-law curve and latches the codes. It then plays twelve bit planes, least significant first. Each plane lasts twice as long as the one before it. Each column line is active low.

After the most significant plane ends, the driver puts out one all-off cycle and raises `frame_done` for that cycle. The row scanner can then advance to the next row and start the next frame. The columns stay dark until that next start. A full frame takes 8190 plane cycles plus the one off cycle.

The sequencer has three named states. IDLE waits for a start; the transition IDLE to PLANE happens on `frame_start` and also latches the codes. PLANE plays the planes; it moves PLANE to PLANE at each plane boundary, and PLANE to BLANK when the last cycle of the most significant plane ends. BLANK is the single off cycle with the done pulse; BLANK to IDLE is unconditional.

Top module: `bcm_column_driver`

## Requirements
- R1: After reset every stored brightness is 0, all `col_n` bits are 1 and `frame_done` is 0.
- R2: The intensity code of a brightness v is floor(v*v / 16), the upper 12 bits of the 16-bit square (v=255 gives 4064, v=4 gives 1, v=3 gives 0).
- R3: During bit plane j, `col_n[c]` is 0 when bit j of column c's code is 1, and 1 when that bit is 0.
- R4: Bit plane j lasts exactly 2^(j+1) clock cycles. Plane 0 is shown from the first cycle after the edge that samples `frame_start`.
- R5: Planes run from j=0 up to j=11 with no gap. The cycle after plane 11 is an all-off cycle (all `col_n` 1) in which `frame_done` is 1 for exactly one cycle; this is cycle 8190, counting plane 0's first cycle as 0.
- R6: After that off cycle, `col_n` stays all 1 and `frame_done` stays 0 until the next accepted start.
- R7: A start uses the twelve stored values of the row given on `start_row` in the same cycle.
- R8: A `frame_start` seen during the planes or the off cycle is ignored; the frame in progress keeps its codes and timing.
- R9: A brightness write made at the same edge as an accepted start, or later in the frame, leaves the running frame unchanged and shows from the next frame of that row.
- R10: A write with `wr_col` of 12 or more changes no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; plane lengths count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store `wr_val` into cell (`wr_row`, `wr_col`) |
| wr_row | input | 3 | Row of the written cell |
| wr_col | input | 4 | Column of the written cell; 12 to 15 are ignored |
| wr_val | input | 8 | Brightness to store |
| frame_start | input | 1 | Begin a frame; accepted only while IDLE |
| start_row | input | 3 | Row whose values the accepted start latches |
| col_n | output | 12 | Active-low column drive, bit c is column c |
| frame_done | output | 1 | One-cycle pulse in the off cycle ending a frame |

## Verification
Two things can land in the same clock edge. One is a brightness write, and the other is the start that latches the same row. The write must not reach the frame that this start launches. The bench drives both at a single edge, with a new value for a cell of the selected row. Every cycle of that frame must then match the old value, and the next frame of the row must show the new one. A second collision is a start pulse that arrives in the off cycle, together with `frame_done`. It must be dropped, and the columns must stay dark afterwards.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLANE = 2'd1,
        ST_BLANK = 2'd2
    } seq_state_t;

endpackage

// File: rtl/bcm_bright_mem.sv
module bcm_bright_mem #(
    parameter int ROWS  = 8,
    parameter int COLS  = 12,
    parameter int VAL_W = 8,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ROW_W-1:0]        wr_row,
    input  logic [COL_W-1:0]        wr_col,
    input  logic [VAL_W-1:0]        wr_val,
    input  logic [ROW_W-1:0]        rd_row,
    output logic [COLS*VAL_W-1:0]   rd_vals
);

    localparam logic [COL_W-1:0] COL_LIMIT = COL_W'(COLS);

    logic [VAL_W-1:0] cell_q [ROWS][COLS];
    logic             wr_ok;

    assign wr_ok = wr_en && (wr_col < COL_LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    cell_q[r][c] <= '0;
                end
            end
        end else if (wr_ok) begin
            cell_q[wr_row][wr_col] <= wr_val;
        end
    end

    for (genvar gc = 0; gc < COLS; gc++) begin : g_rd
        assign rd_vals[gc*VAL_W +: VAL_W] = cell_q[rd_row][gc];
    end

endmodule

// File: rtl/bcm_gamma.sv
module bcm_gamma #(
    parameter int VAL_W  = 8,
    parameter int CODE_W = 12,
    localparam int SQ_W  = 2 * VAL_W
) (
    input  logic [VAL_W-1:0]  level,
    output logic [CODE_W-1:0] code
);

    logic [SQ_W-1:0] square;

    always_comb begin
        square = SQ_W'(level) * SQ_W'(level);
        code   = square[SQ_W-1 -: CODE_W];
    end

endmodule

// File: rtl/bcm_plane_seq.sv
module bcm_plane_seq
    import bcm_pkg::*;
#(
    parameter int CODE_W = 12,
    localparam int PL_W  = $clog2(CODE_W),
    localparam int CNT_W = CODE_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            load,
    output logic            busy,
    output logic            plane_on,
    output logic            done,
    output logic [PL_W-1:0] plane_idx
);

    localparam logic [PL_W-1:0] TOP_PLANE = PL_W'(CODE_W - 1);

    seq_state_t       state_q, state_d;
    logic [PL_W-1:0]  plane_q, plane_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cnt_limit;
    logic             last_tick;

    assign cnt_limit = (CNT_W'(2) << plane_q) - CNT_W'(1);
    assign last_tick = (cnt_q == cnt_limit);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            plane_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            plane_q <= plane_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        plane_d = plane_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_PLANE;
                    plane_d = '0;
                    cnt_d   = '0;
                end
            end
            ST_PLANE: begin
                if (last_tick) begin
                    cnt_d = '0;
                    if (plane_q == TOP_PLANE) begin
                        state_d = ST_BLANK;
                        plane_d = '0;
                    end else begin
                        plane_d = plane_q + PL_W'(1);
                    end
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_BLANK: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        load      = 1'b0;
        busy      = 1'b0;
        plane_on  = 1'b0;
        done      = 1'b0;
        plane_idx = plane_q;
        unique case (state_q)
            ST_IDLE:  load = start;
            ST_PLANE: begin
                busy     = 1'b1;
                plane_on = 1'b1;
            end
            ST_BLANK: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_plane_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        plane_on |-> (plane_idx <= TOP_PLANE));

    assert_plane_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_on && last_tick && plane_idx != TOP_PLANE)
            |=> (plane_on && plane_idx == $past(plane_idx) + PL_W'(1)));

    assert_blank_after_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_on && last_tick && plane_idx == TOP_PLANE) |=> done);

    assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (plane_on && !last_tick) |=> (plane_on && $stable(plane_idx)));

endmodule

// File: rtl/bcm_column_driver.sv
module bcm_column_driver #(
    parameter int ROWS   = 8,
    parameter int COLS   = 12,
    parameter int VAL_W  = 8,
    parameter int CODE_W = 12,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS),
    localparam int PL_W  = $clog2(CODE_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [COL_W-1:0] wr_col,
    input  logic [VAL_W-1:0] wr_val,
    input  logic             frame_start,
    input  logic [ROW_W-1:0] start_row,
    output logic [COLS-1:0]  col_n,
    output logic             frame_done
);

    logic [COLS*VAL_W-1:0]  row_vals;
    logic [COLS*CODE_W-1:0] row_codes;
    logic [COLS*CODE_W-1:0] code_q;
    logic                   load;
    logic                   busy;
    logic                   plane_on;
    logic [PL_W-1:0]        plane_idx;

    bcm_bright_mem #(
        .ROWS  (ROWS),
        .COLS  (COLS),
        .VAL_W (VAL_W)
    ) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_col  (wr_col),
        .wr_val  (wr_val),
        .rd_row  (start_row),
        .rd_vals (row_vals)
    );

    for (genvar gc = 0; gc < COLS; gc++) begin : g_gamma
        bcm_gamma #(
            .VAL_W  (VAL_W),
            .CODE_W (CODE_W)
        ) u_gamma (
            .level (row_vals[gc*VAL_W +: VAL_W]),
            .code  (row_codes[gc*CODE_W +: CODE_W])
        );
    end

    bcm_plane_seq #(
        .CODE_W (CODE_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (frame_start),
        .load      (load),
        .busy      (busy),
        .plane_on  (plane_on),
        .done      (frame_done),
        .plane_idx (plane_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (load) begin
            code_q <= row_codes;
        end
    end

    for (genvar gc = 0; gc < COLS; gc++) begin : g_col
        logic [CODE_W-1:0] col_code;
        assign col_code  = code_q[gc*CODE_W +: CODE_W];
        assign col_n[gc] = plane_on ? ~col_code[plane_idx] : 1'b1;
    end

    assert_dark_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (col_n == '1));

    assert_codes_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(code_q));

    // R8: a start seen while busy must not relaunch plane 0 in the next cycle
    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && frame_start) |=> $stable(code_q));

    assert_dark_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !frame_start) |=> (col_n == '1 || busy));

endmodule

// File: tb/bcm_column_driver_tb.sv
module bcm_column_driver_tb;

    localparam int ROWS   = 8;
    localparam int COLS   = 12;
    localparam int FRAME  = 8190;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_row = '0;
    logic [3:0]  wr_col = '0;
    logic [7:0]  wr_val = '0;
    logic        frame_start = 1'b0;
    logic [2:0]  start_row = '0;
    logic [11:0] col_n;
    logic        frame_done;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    int model [ROWS][COLS];

    bcm_column_driver u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_row      (wr_row),
        .wr_col      (wr_col),
        .wr_val      (wr_val),
        .frame_start (frame_start),
        .start_row   (start_row),
        .col_n       (col_n),
        .frame_done  (frame_done)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    function automatic int gam(input int v);
        return (v * v) >> 4;
    endfunction

    function automatic int plane_of(input int k);
        int s = 0;
        for (int j = 0; j < 12; j++) begin
            if (k < s + (2 << j)) return j;
            s += 2 << j;
        end
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cell(input int r, input int c, input int v);
        @(negedge clk);
        wr_en = 1'b1; wr_row = 3'(r); wr_col = 4'(c); wr_val = 8'(v);
        if (c < COLS) model[r][c] = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // kind: 0 none, 1 start pulse, 2 write; at = -1 drives it with the start
    task automatic run_frame(input int row, input string req,
                             input int kind, input int at,
                             input int ir, input int ic, input int iv);
        int codes [COLS];
        int bad = 0, first_k = -1, first_a = 0, first_e = 0;
        int done_bad = 0, done_k = -1;
        for (int c = 0; c < COLS; c++) codes[c] = gam(model[row][c]);
        @(negedge clk);
        frame_start = 1'b1; start_row = 3'(row);
        if (kind == 2 && at == -1) begin
            wr_en = 1'b1; wr_row = 3'(ir); wr_col = 4'(ic); wr_val = 8'(iv);
            model[ir][ic] = iv;
        end
        for (int k = 0; k <= FRAME + 1; k++) begin
            int exp_cols = 12'hFFF;
            int exp_done = (k == FRAME) ? 1 : 0;
            @(negedge clk);
            frame_start = 1'b0; wr_en = 1'b0;
            if (k < FRAME) begin
                int j = plane_of(k);
                for (int c = 0; c < COLS; c++)
                    if ((codes[c] >> j) & 1) exp_cols &= ~(1 << c);
            end
            if (int'(col_n) != exp_cols) begin
                if (bad == 0) begin first_k = k; first_a = int'(col_n); first_e = exp_cols; end
                bad++;
            end
            if (int'(frame_done) != exp_done) begin
                if (done_bad == 0) done_k = k;
                done_bad++;
            end
            if (kind == 1 && k == at) begin frame_start = 1'b1; start_row = 3'(ir); end
            if (kind == 2 && k == at) begin
                wr_en = 1'b1; wr_row = 3'(ir); wr_col = 4'(ic); wr_val = 8'(iv);
                model[ir][ic] = iv;
            end
        end
        if (bad != 0) $display("  first column mismatch at cycle %0d", first_k);
        check(bad == 0, {req, " R3 R4 columns"}, first_a, first_e);
        check(done_bad == 0, {req, " R5 done at cycle 8190"}, done_k, FRAME);
        @(negedge clk);
        check(col_n == 12'hFFF && !frame_done, {req, " R6 dark after frame"},
              int'({frame_done, col_n}), 12'hFFF);
    endtask

    task automatic t_reset;
        check(col_n == 12'hFFF, "R1 columns off at reset", int'(col_n), 12'hFFF);
        check(frame_done == 1'b0, "R1 done low at reset", int'(frame_done), 0);
        run_frame(0, "R1 zero memory", 0, 0, 0, 0, 0);
    endtask

    task automatic t_gamma;
        int vals [COLS] = '{0, 1, 3, 4, 5, 16, 64, 100, 128, 200, 254, 255};
        for (int c = 0; c < COLS; c++) write_cell(2, c, vals[c]);
        check(gam(255) == 4064 && gam(4) == 1 && gam(3) == 0, "R2 model codes", gam(255), 4064);
        run_frame(2, "R2 gamma row2", 0, 0, 0, 0, 0);
    endtask

    task automatic t_row_select;
        for (int c = 0; c < COLS; c++) write_cell(5, c, 255 - 20 * c);
        run_frame(5, "R7 row5", 0, 0, 0, 0, 0);
        run_frame(2, "R7 row2 again", 0, 0, 0, 0, 0);
    endtask

    task automatic t_start_busy;
        run_frame(2, "R8 start mid-plane", 1, 100, 5, 0, 0);
        run_frame(5, "R8 start in off cycle", 1, FRAME, 2, 0, 0);
    endtask

    task automatic t_write_during;
        run_frame(2, "R9 write mid-frame", 2, 3000, 2, 0, 255);
        run_frame(2, "R9 next frame shows write", 0, 0, 0, 0, 0);
        run_frame(5, "R9 write with start", 2, -1, 5, 11, 7);
        run_frame(5, "R9 next frame after same-edge write", 0, 0, 0, 0, 0);
    endtask

    task automatic t_col_range;
        write_cell(3, 14, 255);
        write_cell(3, 12, 255);
        run_frame(3, "R10 out-of-range column", 0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) model[r][c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gamma();
        t_row_select();
        t_start_busy();
        t_write_during();
        t_col_range();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule